// File: doc/BRIEF.md
# DMA Chain Table Reload Sequencer

This block loads the register file of one DMA channel from a parameter table held in memory. A chain pointer, written by the local processor or taken from the previous table, gives the byte address of the table. A start-chain command makes the block read the table's header word. Ten select bits in that header name the channel registers that follow. The block then reads just those entries, one word at a time over a simple request/acknowledge read port, and presents each word on a register-file write strobe together with a register index and a word index.

Tables therefore vary in length. The last possible entry is a new chain pointer, which becomes the start address of the next chain operation. When the last selected word has been written, the block raises a one-cycle completion pulse. With that pulse it also raises an auto-start flag when the channel mode loaded in this table asks the channel to run by itself. The channel registers, the data mover, memory arbitration and interrupts lie outside the block.

Top module: `chain_reload_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `mem_req_o`, `wr_en_o`, `done_o` and `auto_start_o` are 0, and `chain_abort_o` is 1.
- R2: While `chain_abort_o` is 1, `start_i` is ignored, so no memory request follows. A `ca_load_i` pulse loads the chain pointer from `{ca_seg_i, ca_off_i}` and clears `chain_abort_o` from the next cycle on.
- R3: An accepted start first reads the header word at the chain pointer's address. Header bits 15 to 10 have no effect.
- R4: Only the entries whose header bit is set are read and written, packed with no gaps, from bit 9 down to bit 0. `wr_sel_o` gives the bit number: 9 current address A, 8 current address B, 7 current count, 6 base address A, 5 base address B, 4 base count, 3 pattern/mask, 2 vector, 1 channel mode, 0 chain pointer.
- R5: Entries 7, 4 and 2 are one word long, with `wr_word_o`=0. Every other entry is two words: `wr_word_o`=0 for the first word (segment/tag, mode high, pattern) and then `wr_word_o`=1 for the second (offset, mode low, mask).
- R6: Each table word is read at an address 2 bytes above the previous one, carrying across the full 22-bit address. `mem_req_o` and `mem_addr_o` hold steady until `mem_ack_i`.
- R7: The word acknowledged in cycle c is written (`wr_en_o`=1, `wr_data_o` = that word) in cycle c+1. `done_o` is high for exactly the cycle after the last write. A header with all ten select bits clear gives no writes, and `done_o` rises in the cycle after the header is acknowledged.
- R8: `auto_start_o` is high together with `done_o` exactly when this table loaded the channel mode entry and bit 4 of its first (high) word is 1.
- R9: A chain pointer entry in the table takes effect only from the next start. Its first word's bits 5 to 0 become address bits 21 to 16, and its second word becomes bits 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-chain command pulse |
| ca_load_i | input | 1 | Processor load of the chain pointer |
| ca_seg_i | input | 6 | Chain pointer address bits 21..16 |
| ca_off_i | input | 16 | Chain pointer address bits 15..0 |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 22 | Read byte address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | 16 | Read data |
| wr_en_o | output | 1 | Register-file write strobe |
| wr_sel_o | output | 4 | Register index (header bit number) |
| wr_word_o | output | 1 | Word index within the entry |
| wr_data_o | output | 16 | Word to write |
| busy_o | output | 1 | Chain in progress |
| done_o | output | 1 | One-cycle completion pulse |
| auto_start_o | output | 1 | Channel should start after this chain |
| chain_abort_o | output | 1 | Chain pointer not yet loaded since reset |

## Verification
The assertions take for granted that `mem_ack_i` is high only while `mem_req_o` is high, and that `start_i` is pulsed only while `busy_o` is low. The bench's memory model acknowledges only a pending request, and it inserts zero, one or two wait cycles, chosen from the header value. The sweep covers all 1024 header select patterns. Each header also carries different filler in its upper bits, and one table address is chosen so that the reads carry across the 64 KiB boundary.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam int NSEL = 10;
  localparam int SELW = $clog2(NSEL);
  localparam int SEL_MODE  = 1;
  localparam int SEL_CHAIN = 0;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DATA} crs_state_e;

  // Entries 7 (current count), 4 (base count) and 2 (vector) are one word long.
  function automatic logic one_word(input logic [SELW-1:0] s);
    return (s == SELW'(7)) || (s == SELW'(4)) || (s == SELW'(2));
  endfunction
endpackage

// File: rtl/crs_pick.sv
module crs_pick #(
  parameter int N  = 10,
  parameter int IW = 4
) (
  input  logic [N-1:0]  pend_i,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  rest_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i]) idx_o = IW'(i);
    end
  end

  assign rest_o = pend_i & ~(N'(1) << idx_o);
endmodule

// File: rtl/crs_addr.sv
module crs_addr #(
  parameter int ADDR_W = 22,
  parameter int OFF_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_ld_i,
  input  logic [ADDR_W-OFF_W-1:0] cpu_seg_i,
  input  logic [OFF_W-1:0]        cpu_off_i,
  input  logic                    commit_i,
  input  logic [ADDR_W-1:0]       commit_addr_i,
  input  logic                    begin_i,
  input  logic                    step_i,
  output logic [ADDR_W-1:0]       ptr_o,
  output logic                    abort_o
);
  logic [ADDR_W-1:0] chain_q, chain_d, ptr_q, ptr_d;
  logic              abort_q, abort_d;

  always_comb begin
    chain_d = chain_q;
    abort_d = abort_q;
    ptr_d   = ptr_q;
    if (commit_i) begin
      chain_d = commit_addr_i;
      abort_d = 1'b0;
    end
    if (cpu_ld_i) begin
      chain_d = {cpu_seg_i, cpu_off_i};
      abort_d = 1'b0;
    end
    if (begin_i)     ptr_d = chain_q;
    else if (step_i) ptr_d = ptr_q + ADDR_W'(2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      abort_q <= 1'b1;
      ptr_q   <= '0;
    end else begin
      chain_q <= chain_d;
      abort_q <= abort_d;
      ptr_q   <= ptr_d;
    end
  end

  assign ptr_o   = ptr_q;
  assign abort_o = abort_q;

  // R2: a processor load of the pointer clears the abort flag
  a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ld_i |=> !abort_o);
endmodule

// File: rtl/chain_reload_seq.sv
module chain_reload_seq
  import crs_pkg::*;
#(
  parameter int DW        = 16,
  parameter int ADDR_W    = 22,
  parameter int OFF_W     = 16,
  parameter int SWREQ_BIT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    ca_load_i,
  input  logic [ADDR_W-OFF_W-1:0] ca_seg_i,
  input  logic [OFF_W-1:0]        ca_off_i,
  output logic                    mem_req_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  input  logic                    mem_ack_i,
  input  logic [DW-1:0]           mem_rdata_i,
  output logic                    wr_en_o,
  output logic [SELW-1:0]         wr_sel_o,
  output logic                    wr_word_o,
  output logic [DW-1:0]           wr_data_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    auto_start_o,
  output logic                    chain_abort_o
);
  localparam int SEG_W = ADDR_W - OFF_W;

  crs_state_e         st_q, st_d;
  logic [NSEL-1:0]    pend_q, pend_d, rest;
  logic [SELW-1:0]    cur;
  logic               wcnt_q, wcnt_d;
  logic               wr_en_q, wr_en_d, last_q, last_d, done_q, done_d;
  logic [SELW-1:0]    wr_sel_q, wr_sel_d;
  logic               wr_word_q, wr_word_d;
  logic [DW-1:0]      wr_data_q, wr_data_d;
  logic               auto_q, auto_d, cpend_q, cpend_d;
  logic [SEG_W-1:0]   cseg_q, cseg_d;
  logic [OFF_W-1:0]   coff_q, coff_d;
  logic               accept, commit, abort_w;

  crs_pick #(.N(NSEL), .IW(SELW)) u_pick (
    .pend_i (pend_q),
    .idx_o  (cur),
    .rest_o (rest)
  );

  crs_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_ld_i      (ca_load_i),
    .cpu_seg_i     (ca_seg_i),
    .cpu_off_i     (ca_off_i),
    .commit_i      (commit),
    .commit_addr_i ({cseg_q, coff_q}),
    .begin_i       (accept),
    .step_i        (mem_req_o && mem_ack_i),
    .ptr_o         (mem_addr_o),
    .abort_o       (abort_w)
  );

  assign mem_req_o = (st_q == ST_HDR) || (st_q == ST_DATA);
  assign accept    = start_i && (st_q == ST_IDLE) && !wr_en_q && !abort_w;

  always_comb begin
    st_d      = st_q;
    pend_d    = pend_q;
    wcnt_d    = wcnt_q;
    wr_en_d   = 1'b0;
    wr_sel_d  = wr_sel_q;
    wr_word_d = wr_word_q;
    wr_data_d = wr_data_q;
    last_d    = 1'b0;
    done_d    = wr_en_q && last_q;
    auto_d    = auto_q;
    cpend_d   = cpend_q;
    cseg_d    = cseg_q;
    coff_d    = coff_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d    = ST_HDR;
          pend_d  = '0;
          wcnt_d  = 1'b0;
          auto_d  = 1'b0;
          cpend_d = 1'b0;
        end
      end
      ST_HDR: begin
        if (mem_ack_i) begin
          pend_d = mem_rdata_i[NSEL-1:0];
          if (mem_rdata_i[NSEL-1:0] == '0) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            st_d = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (mem_ack_i) begin
          wr_en_d   = 1'b1;
          wr_sel_d  = cur;
          wr_word_d = wcnt_q;
          wr_data_d = mem_rdata_i;
          if (cur == SELW'(SEL_MODE) && !wcnt_q) auto_d = mem_rdata_i[SWREQ_BIT];
          if (cur == SELW'(SEL_CHAIN)) begin
            if (!wcnt_q) cseg_d = mem_rdata_i[SEG_W-1:0];
            else begin
              coff_d  = mem_rdata_i[OFF_W-1:0];
              cpend_d = 1'b1;
            end
          end
          if (one_word(cur) || wcnt_q) begin
            wcnt_d = 1'b0;
            pend_d = rest;
            if (rest == '0) begin
              st_d   = ST_IDLE;
              last_d = 1'b1;
            end
          end else begin
            wcnt_d = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign commit = done_d && cpend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pend_q  <= '0;
      wcnt_q  <= 1'b0;
      wr_en_q <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      auto_q  <= 1'b0;
      cpend_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      wcnt_q  <= wcnt_d;
      wr_en_q <= wr_en_d;
      last_q  <= last_d;
      done_q  <= done_d;
      auto_q  <= auto_d;
      cpend_q <= cpend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sel_q  <= '0;
      wr_word_q <= 1'b0;
      wr_data_q <= '0;
      cseg_q    <= '0;
      coff_q    <= '0;
    end else if (wr_en_d) begin
      wr_sel_q  <= wr_sel_d;
      wr_word_q <= wr_word_d;
      wr_data_q <= wr_data_d;
      cseg_q    <= cseg_d;
      coff_q    <= coff_d;
    end
  end

  assign wr_en_o       = wr_en_q;
  assign wr_sel_o      = wr_sel_q;
  assign wr_word_o     = wr_word_q;
  assign wr_data_o     = wr_data_q;
  assign done_o        = done_q;
  assign auto_start_o  = done_q && auto_q;
  assign busy_o        = (st_q != ST_IDLE) || wr_en_q;
  assign chain_abort_o = abort_w;

  // R6: request and address stay put until acknowledged
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R6: the next read of the same table sits 2 bytes higher
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_ack_i) |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) + ADDR_W'(2)));
  // R7: completion is a single-cycle pulse with the bus quiet
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!mem_req_o && !wr_en_o));
  // R2: an aborted channel never leaves idle
  a_r2_abort_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_abort_o && !busy_o) |=> !busy_o);
  // R8: auto-start only accompanies completion
  a_r8_auto_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    auto_start_o |-> done_o);
  // R5: one-word entries never show a second word
  a_r5_single_word: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && one_word(wr_sel_o)) |-> !wr_word_o);
endmodule

// File: tb/chain_reload_seq_bench.sv
module chain_reload_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, ca_load_i = 1'b0;
  logic [5:0]  ca_seg_i = '0;
  logic [15:0] ca_off_i = '0;
  logic        mem_req_o, mem_ack_i = 1'b0;
  logic [21:0] mem_addr_o;
  logic [15:0] mem_rdata_i = '0;
  logic        wr_en_o, wr_word_o, busy_o, done_o, auto_start_o, chain_abort_o;
  logic [3:0]  wr_sel_o;
  logic [15:0] wr_data_o;

  chain_reload_seq u_chain_reload_seq (.*);

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;
  logic [15:0] mem [0:511];
  int  exp_sel [0:31];
  int  exp_word [0:31];
  logic [15:0] exp_data [0:31];
  int  nexp = 0, widx = 0, nfetch = 0, lat = 0, waitc = 0, last_ev = -10;
  logic [21:0] base_run = '0, exp_ca = '0;
  bit  exp_auto = 0, done_seen = 0, active = 0;

  localparam logic [21:0] BASE_A = {6'h01, 16'hFFF0};
  localparam logic [21:0] BASE_B = {6'h2A, 16'h0200};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", what, act, expv, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // memory responder: acks only pending requests, with lat wait cycles
  always @(negedge clk) begin
    mem_ack_i = 1'b0;
    if (mem_req_o && rst_n) begin
      if (waitc >= lat) begin
        logic [21:0] ea;
        ea = base_run + 22'(2 * nfetch);
        if (nfetch == 0) chk(mem_addr_o == ea, "R3 header address", mem_addr_o, ea);
        else             chk(mem_addr_o == ea, "R6 word address", mem_addr_o, ea);
        mem_rdata_i = mem[mem_addr_o[9:1]];
        mem_ack_i   = 1'b1;
        if (nfetch == 0 && nexp == 0) last_ev = cyc;
        nfetch++;
        waitc = 0;
      end else begin
        waitc++;
      end
    end
  end

  // write/done monitor
  always @(negedge clk) begin
    if (rst_n && wr_en_o) begin
      if (widx < nexp) begin
        chk(wr_sel_o == 4'(exp_sel[widx]), "R4 register index", wr_sel_o, exp_sel[widx]);
        chk(wr_word_o == exp_word[widx][0], "R5 word index", wr_word_o, exp_word[widx]);
        chk(wr_data_o == exp_data[widx], "R7 write data", wr_data_o, exp_data[widx]);
      end else begin
        chk(0, "R4 unexpected write", widx, nexp);
      end
      widx++;
      if (widx == nexp) last_ev = cyc;
    end
    if (rst_n && done_o) begin
      chk(active, "R7 done without chain", 1, 0);
      chk(cyc == last_ev + 1, "R7 done timing", cyc - last_ev, 1);
      chk(widx == nexp, "R4 write count", widx, nexp);
      chk(auto_start_o == exp_auto, "R8 auto start", auto_start_o, exp_auto);
      done_seen = 1;
      active = 0;
    end
  end

  function automatic bit single(input int b);
    return (b == 7) || (b == 4) || (b == 2);
  endfunction

  task automatic run_chain(input int m, input int latency);
    int k;
    logic [21:0] nxt;
    logic [15:0] d;
    nxt = (exp_ca == BASE_A) ? BASE_B : BASE_A;
    nexp = 0; widx = 0; nfetch = 0; waitc = 0; exp_auto = 0;
    lat = latency;
    base_run = exp_ca;
    k = 0;
    mem[base_run[9:1]] = {6'(m * 5 + 3), 10'(m)};
    for (int b = 9; b >= 0; b--) begin
      if (m[b]) begin
        for (int w = 0; w < (single(b) ? 1 : 2); w++) begin
          d = 16'(m * 37 + b * 4099 + w * 211 + 17);
          if (b == 1 && w == 0) begin
            d[4] = m[4] ^ m[7];
            exp_auto = d[4];
          end
          if (b == 0) d = (w == 0) ? {10'h2B5, nxt[21:16]} : nxt[15:0];
          k++;
          mem[9'((base_run >> 1) + 22'(k))] = d;
          exp_sel[nexp] = b; exp_word[nexp] = w; exp_data[nexp] = d;
          nexp++;
        end
      end
    end
    done_seen = 0;
    active = 1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 0; t < 300 && !done_seen; t++) @(negedge clk);
    chk(done_seen, "R7 chain completion", done_seen, 1);
    if (!done_seen) summary();
    chk(busy_o == 1'b0, "R7 idle after done", busy_o, 0);
    if (m[0]) exp_ca = nxt; // R9: pointer applies to the next start only
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 16'hDEAD;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy_o == 0 && mem_req_o == 0 && wr_en_o == 0, "R1 idle outputs", {busy_o, mem_req_o, wr_en_o}, 0);
    chk(done_o == 0 && auto_start_o == 0, "R1 no pulses", {done_o, auto_start_o}, 0);
    chk(chain_abort_o == 1, "R1 abort set", chain_abort_o, 1);
    // R2 start ignored while aborted
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 0; t < 4; t++) begin
      chk(mem_req_o == 0 && busy_o == 0, "R2 start ignored", {mem_req_o, busy_o}, 0);
      @(negedge clk);
    end
    ca_load_i = 1'b1; ca_seg_i = BASE_A[21:16]; ca_off_i = BASE_A[15:0];
    @(negedge clk);
    ca_load_i = 1'b0;
    chk(chain_abort_o == 0, "R2 abort cleared", chain_abort_o, 1'b0);
    exp_ca = BASE_A;
    // full sweep of select patterns (R3..R9)
    for (int m = 0; m < 1024; m++) begin
      run_chain(m, m % 3);
      @(negedge clk);
    end
    // R9: processor reload of the pointer moves the next table
    ca_load_i = 1'b1; ca_seg_i = BASE_B[21:16]; ca_off_i = BASE_B[15:0];
    @(negedge clk);
    ca_load_i = 1'b0;
    exp_ca = BASE_B;
    run_chain(10'h283, 1);
    run_chain(10'h001, 0);
    run_chain(10'h0C0, 2);
    summary();
  end
endmodule